// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects small data words held in storage. On the write side it takes a data word and produces a code word: the data bits unchanged in the low positions, followed by check bits. Each check bit is the even parity of a fixed subset of the data bits. On the read side it takes a code word that may have been damaged. It recomputes the check bits from the stored data and XORs them with the stored check bits to form a syndrome. It then returns the data together with a classification: clean, one flipped bit repaired (with that bit's index), or damage too heavy to repair.

Each code-word position owns a column of the parity-check matrix. Every column is nonzero, distinct and of odd weight. The check positions use unit columns. The data positions use the lightest odd columns of weight three or more, taken in ascending numeric order. This keeps the XOR trees small. The default is a 4-bit data word with 4 check bits, giving an 8-bit code word of distance 4. A 64-bit word with 8 check bits uses the same rule.

The encode path and the decode path are independent. Each has one output register that loads when its input is valid.

Top module: `secded_codec`

## Requirements
- R1: One cycle after `enc_valid`, `enc_out_valid` is 1 and `enc_word[3:0]` equals the data. The check bits (default widths) are `enc_word[4]=d0^d1^d2`, `enc_word[5]=d0^d1^d3`, `enc_word[6]=d0^d2^d3` and `enc_word[7]=d1^d2^d3`. `enc_word` holds its value in cycles without `enc_valid`.
- R2: A decoded word whose syndrome is zero gives `data_out` equal to bits [3:0] of the word, with `err_single=0`, `err_double=0` and `err_pos=0`.
- R3: A word with exactly one data bit i (0..3) inverted gives the original data on `data_out`, with `err_single=1`, `err_double=0` and `err_pos=i`.
- R4: A word with exactly one check bit inverted (position 4..7) gives `data_out` equal to the received data bits, with `err_single=1` and `err_pos` equal to that position.
- R5: Any nonzero syndrome that matches no column, which includes every two-bit error, gives `err_double=1`, `err_single=0`, `err_pos=0`, and `data_out` equal to the received data bits.
- R6: `dec_out_valid` equals `dec_valid` delayed by one cycle. `data_out`, `err_single`, `err_double` and `err_pos` change only in the cycle after `dec_valid`.
- R7: While `rst_n` is low, every output is zero.
- R8: `err_single` and `err_double` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid | input | 1 | Encode request |
| enc_data | input | DATA_W | Data word to encode |
| enc_out_valid | output | 1 | Encoded word valid |
| enc_word | output | DATA_W+CHK_W | Code word: data low, check bits high |
| dec_valid | input | 1 | Decode request |
| dec_word | input | DATA_W+CHK_W | Stored code word to check |
| dec_out_valid | output | 1 | Decode result valid |
| data_out | output | DATA_W | Corrected data |
| err_single | output | 1 | One bit was repaired |
| err_double | output | 1 | Uncorrectable damage |
| err_pos | output | clog2(DATA_W+CHK_W) | Index of the repaired bit |

## Verification
A wrong column in the matrix shows up one cycle after the first affected encode, as a wrong check bit. It also shows up as a misplaced `err_pos` on the first single-bit error whose syndrome lands on that column. A stuck or mis-decoded syndrome bit turns clean words into false repairs, or double errors into miscorrections, on the very next decode result. Because the bench sweeps every data value with every one- and two-bit flip, each such fault is exposed within a few hundred cycles. Any register that loads without a valid input is caught by the hold cycles placed between requests.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of ones in a vector of up to 16 bits.
  function automatic int ones16(input logic [15:0] v);
    int n;
    n = 0;
    for (int b = 0; b < 16; b++) n += int'(v[b]);
    return n;
  endfunction

  // Column of the parity-check matrix for code-word position pos.
  // Check positions (pos >= dw) use unit columns. Data positions use the
  // odd-weight columns of weight three and up: lightest weight first,
  // ascending value within a weight.
  function automatic logic [15:0] hcol(input int pos, input int dw, input int cw);
    logic [15:0] res;
    int k;
    res = '0;
    k = 0;
    if (pos >= dw) begin
      res[pos - dw] = 1'b1;
    end else begin
      for (int w = 3; w <= cw; w += 2) begin
        for (int v = 1; v < (1 << cw); v++) begin
          if (ones16(16'(v)) == w) begin
            if (k == pos) res = 16'(v);
            k++;
          end
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_chkgen.sv
module secded_chkgen #(
  parameter int DATA_W = 4,
  parameter int CHK_W  = 4
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [CHK_W-1:0] cols [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [15:0] HC = secded_pkg::hcol(i, DATA_W, CHK_W);
    assign cols[i] = HC[CHK_W-1:0];
  end

  // Each check bit is the XOR of the data bits whose column has that row set.
  always_comb begin
    chk = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int r = 0; r < CHK_W; r++) begin
        if (cols[i][r]) chk[r] = chk[r] ^ data[i];
      end
    end
  end
endmodule

// File: rtl/secded_locate.sv
module secded_locate #(
  parameter int DATA_W = 4,
  parameter int CHK_W  = 4,
  localparam int N     = DATA_W + CHK_W,
  localparam int POS_W = $clog2(N)
) (
  input  logic [CHK_W-1:0] syn,
  output logic [N-1:0]     match,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  for (genvar j = 0; j < N; j++) begin : g_match
    localparam logic [15:0] HC = secded_pkg::hcol(j, DATA_W, CHK_W);
    assign match[j] = (syn == HC[CHK_W-1:0]);
  end

  assign hit = |match;

  // Columns are distinct, so at most one match bit is set.
  always_comb begin
    pos = '0;
    for (int j = 0; j < N; j++) begin
      if (match[j]) pos = pos | POS_W'(j);
    end
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DATA_W = 4,
  parameter int CHK_W  = 4,
  localparam int N     = DATA_W + CHK_W,
  localparam int POS_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid,
  input  logic [DATA_W-1:0] enc_data,
  output logic              enc_out_valid,
  output logic [N-1:0]      enc_word,
  input  logic              dec_valid,
  input  logic [N-1:0]      dec_word,
  output logic              dec_out_valid,
  output logic [DATA_W-1:0] data_out,
  output logic              err_single,
  output logic              err_double,
  output logic [POS_W-1:0]  err_pos
);
  // ---- encode path ----
  logic [CHK_W-1:0] enc_chk;

  secded_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_gen (
    .data (enc_data),
    .chk  (enc_chk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_out_valid <= 1'b0;
      enc_word      <= '0;
    end else begin
      enc_out_valid <= enc_valid;
      if (enc_valid) enc_word <= {enc_chk, enc_data};
    end
  end

  // ---- decode path ----
  logic [DATA_W-1:0] rx_data;
  logic [CHK_W-1:0]  rx_chk;
  logic [CHK_W-1:0]  re_chk;
  logic [CHK_W-1:0]  syn;
  logic [N-1:0]      match;
  logic              syn_hit;
  logic              syn_zero;
  logic              syn_bad;
  logic [POS_W-1:0]  hit_pos;
  logic [DATA_W-1:0] fixed_data;

  assign rx_data = dec_word[DATA_W-1:0];
  assign rx_chk  = dec_word[N-1:DATA_W];

  secded_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec_gen (
    .data (rx_data),
    .chk  (re_chk)
  );

  assign syn      = rx_chk ^ re_chk;
  assign syn_zero = (syn == '0);

  secded_locate #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_locate (
    .syn   (syn),
    .match (match),
    .hit   (syn_hit),
    .pos   (hit_pos)
  );

  // Nonzero syndrome that names no position: uncorrectable.
  assign syn_bad    = !syn_zero && !syn_hit;
  assign fixed_data = rx_data ^ match[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_out_valid <= 1'b0;
      data_out      <= '0;
      err_single    <= 1'b0;
      err_double    <= 1'b0;
      err_pos       <= '0;
    end else begin
      dec_out_valid <= dec_valid;
      if (dec_valid) begin
        data_out   <= fixed_data;
        err_single <= syn_hit;
        err_double <= syn_bad;
        err_pos    <= hit_pos;
      end
    end
  end

  // ---- assertions ----
  a_r1_data_systematic: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> (enc_out_valid && enc_word[DATA_W-1:0] == $past(enc_data)));

  a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && syn_zero) |=>
      (data_out == $past(rx_data) && !err_single && !err_double && err_pos == '0));

  a_r3_one_location: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $onehot0(match));

  a_r5_bad_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && syn_bad) |=> (err_double && data_out == $past(rx_data) && err_pos == '0));

  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_out_valid);

  a_r6_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !dec_out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(data_out) && $stable(err_single) &&
                    $stable(err_double) && $stable(err_pos)));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_double));

endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid = 1'b0;
  logic [3:0] enc_data = '0;
  logic       enc_out_valid;
  logic [7:0] enc_word;
  logic       dec_valid = 1'b0;
  logic [7:0] dec_word = '0;
  logic       dec_out_valid;
  logic [3:0] data_out;
  logic       err_single;
  logic       err_double;
  logic [2:0] err_pos;

  always #5 clk = ~clk;

  secded_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_data(enc_data),
    .enc_out_valid(enc_out_valid), .enc_word(enc_word),
    .dec_valid(dec_valid), .dec_word(dec_word),
    .dec_out_valid(dec_out_valid), .data_out(data_out),
    .err_single(err_single), .err_double(err_double), .err_pos(err_pos)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model state (what the outputs should show next)
  logic       m_ev = 0;
  logic [7:0] m_ew = '0;
  logic       m_dv = 0;
  logic [3:0] m_do = '0;
  logic       m_s = 0;
  logic       m_d = 0;
  logic [2:0] m_p = '0;
  string      m_etag = "R7";
  string      m_dtag = "R7";

  function automatic logic [7:0] ref_enc(input logic [3:0] d);
    logic [7:0] w;
    w[3:0] = d;
    w[4] = d[0] ^ d[1] ^ d[2];
    w[5] = d[0] ^ d[1] ^ d[3];
    w[6] = d[0] ^ d[2] ^ d[3];
    w[7] = d[1] ^ d[2] ^ d[3];
    return w;
  endfunction

  function automatic bit is_code(input logic [7:0] w);
    return ref_enc(w[3:0]) == w;
  endfunction

  task automatic cmp(input int act, input int exp, input string rq, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp(int'(enc_out_valid), int'(m_ev), "R1", "enc_out_valid");
    cmp(int'(enc_word), int'(m_ew), m_etag, "enc_word");
    cmp(int'(dec_out_valid), int'(m_dv), "R6", "dec_out_valid");
    cmp(int'(data_out), int'(m_do), m_dtag, "data_out");
    cmp(int'(err_single), int'(m_s), m_dtag, "err_single");
    cmp(int'(err_double), int'(m_d), m_dtag, "err_double");
    cmp(int'(err_pos), int'(m_p), m_dtag, "err_pos");
    if (err_single && err_double) cmp(1, 0, "R8", "both flags");
  endtask

  // One clock: compare the outputs, then drive the inputs and advance the model.
  task automatic cyc(input logic ev, input logic [3:0] ed,
                     input logic dv, input logic [7:0] dw, input string rq);
    @(negedge clk);
    check_all();
    enc_valid = ev; enc_data = ed; dec_valid = dv; dec_word = dw;
    m_ev = ev;
    if (ev) begin m_ew = ref_enc(ed); m_etag = "R1"; end
    m_dv = dv;
    if (dv) begin
      m_dtag = rq;
      m_do = dw[3:0]; m_s = 0; m_d = 0; m_p = 0;
      if (!is_code(dw)) begin
        m_d = 1;
        for (int j = 0; j < 8; j++) begin
          if (is_code(dw ^ (8'd1 << j))) begin
            m_d = 0; m_s = 1; m_p = 3'(j);
            m_do = dw[3:0] ^ ((j < 4) ? 4'(1 << j) : 4'd0);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R7: reset values with the clock running
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_all();
    end
    rst_n = 1'b1;

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      cw = ref_enc(4'(d));
      cyc(1'b1, 4'(d), 1'b1, cw, "R2");           // encode + clean decode
      cyc(1'b0, 4'hF, 1'b0, 8'hA5, "R6");         // hold: nothing loads
      for (int b = 0; b < 8; b++) begin
        cyc(1'b0, 4'(d), 1'b1, cw ^ (8'd1 << b), (b < 4) ? "R3" : "R4");
      end
      for (int a = 0; a < 8; a++) begin
        for (int b = a + 1; b < 8; b++) begin
          cyc(1'b0, 4'(d), 1'b1, cw ^ (8'd1 << a) ^ (8'd1 << b), "R5");
        end
      end
      cyc(1'b0, 4'h0, 1'b0, ~cw, "R6");            // hold after a double
    end
    cyc(1'b0, 4'h0, 1'b0, 8'h00, "R6");
    cyc(1'b0, 4'h0, 1'b0, 8'h00, "R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule